// File: doc/BRIEF.md
# Adaptive Delta Modulation Encoder

This block turns a stream of signed PCM samples into a one-bit adaptive delta modulation bitstream. Each time the sample strobe is high, the incoming sample is compared with an internal running estimate of the signal. The result is captured as the output bit: 1 when the sample is at or above the estimate, 0 when it is below. On the following cycle, a small step controller looks at the new bit and the bit before it. Then the estimate is moved up or down by the selected step. The estimate is a digital integrator, so a decoder that runs the same step rule can rebuild the waveform from the bits alone.

The step controller is a two-bit run counter. A run of equal bits shows that the estimate is lagging behind the signal, so each further equal bit raises the count by one, up to its ceiling, where it stays. A change of bit polarity shows that the estimate has crossed the signal, so the count drops back to zero. The step magnitude is the count plus one, which gives steps of 1 to 4 units. A steep input therefore gets large steps and a quiet input gets fine ones. The estimate saturates at the ends of the input's signed range and never wraps.

The bit, the step index and the estimate are presented continuously. They change only as a result of a strobe.

Top module: `adm_encoder`

## Requirements
- R1: In a strobe cycle, `adm_bit` is loaded with 1 if the signed `smp_in` is greater than or equal to the estimate that the comparator sees, and with 0 otherwise. The new bit appears one clock after the strobe.
- R2: The step index (`step_idx`) is cleared to 0 when the new bit differs from the bit registered at the strobe before it. The previous bit starts at 0 after reset.
- R3: When the new bit equals the previous bit, the step index increases by one. Once it reaches 3 it stays at 3 and does not wrap.
- R4: The step magnitude is `step_idx + 1` units (1, 2, 3 or 4), using the index after its update. The estimate rises by that magnitude when the new bit is 1 and falls by it when the bit is 0.
- R5: The estimate clamps to the range -2048 to 2047 (for the default 12-bit input) and does not wrap.
- R6: The step index and the estimate update in the cycle after the strobe, so they appear two clocks after the strobe and one clock after the bit.
- R7: When no strobe is present and no update is pending, all outputs hold, whatever `smp_in` does.
- R8: Synchronous reset clears the bit, the previous bit, the step index and the estimate to 0.
- R9: If a strobe arrives in the same cycle as a pending update, the comparison uses the estimate that this update is producing, not the stale one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | Sample strobe |
| smp_in | input | IN_W | Signed input sample |
| adm_bit | output | 1 | Registered modulation bit |
| step_idx | output | CNT_W | Current step index (step = index + 1 units) |
| estimate | output | IN_W | Signed reconstructed estimate |

## Verification
Two actions can fall in the same cycle: the integrator update left pending by one strobe, and the comparison made for a strobe that follows it at once. The bench provokes this by holding the strobe high for two consecutive cycles. The second sample is chosen to lie between the stale estimate and the updated one, so the bit it produces shows which value the comparator used. The step index and estimate that result are then checked against values worked out by hand from the rules.

// File: rtl/adm_encoder.sv
module adm_encoder #(
  parameter int IN_W      = 12,
  parameter int CNT_W     = 2,
  parameter int STEP_UNIT = 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   smp_vld,
  input  logic signed [IN_W-1:0] smp_in,
  output logic                   adm_bit,
  output logic [CNT_W-1:0]       step_idx,
  output logic signed [IN_W-1:0] estimate
);
  localparam int ACC_W = IN_W + CNT_W + 2;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic signed [ACC_W-1:0] EST_HI =
    {{(ACC_W-IN_W+1){1'b0}}, {(IN_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] EST_LO =
    {{(ACC_W-IN_W+1){1'b1}}, {(IN_W-1){1'b0}}};

  logic                   bit_q, prev_q, pend_q;
  logic [CNT_W-1:0]       cnt_q, cnt_upd;
  logic signed [IN_W-1:0] est_q, est_upd, est_eff;
  logic signed [ACC_W-1:0] acc_cur, step_mag, acc_sum;

  assign cnt_upd = (bit_q != prev_q) ? '0 :
                   (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;

  assign step_mag = $signed((ACC_W'(cnt_upd) + ACC_W'(1)) * ACC_W'(STEP_UNIT));
  assign acc_cur  = {{(ACC_W-IN_W){est_q[IN_W-1]}}, est_q};
  assign acc_sum  = bit_q ? acc_cur + step_mag : acc_cur - step_mag;

  always_comb begin
    if (acc_sum > EST_HI)      est_upd = EST_HI[IN_W-1:0];
    else if (acc_sum < EST_LO) est_upd = EST_LO[IN_W-1:0];
    else                       est_upd = acc_sum[IN_W-1:0];
  end

  assign est_eff = pend_q ? est_upd : est_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q  <= 1'b0;
      prev_q <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
      est_q  <= '0;
    end else begin
      if (pend_q) begin
        cnt_q <= cnt_upd;
        est_q <= est_upd;
      end
      if (smp_vld) begin
        bit_q  <= (smp_in >= est_eff);
        prev_q <= bit_q;
      end
      pend_q <= smp_vld;
    end
  end

  assign adm_bit  = bit_q;
  assign step_idx = cnt_q;
  assign estimate = est_q;
endmodule

module adm_encoder_chk #(
  parameter int IN_W  = 12,
  parameter int CNT_W = 2
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   smp_vld,
  input logic signed [IN_W-1:0] smp_in,
  input logic                   adm_bit,
  input logic [CNT_W-1:0]       step_idx,
  input logic signed [IN_W-1:0] estimate,
  input logic                   pend
);
  localparam logic [CNT_W-1:0] IDX_MAX = '1;

  assert_cmp_R1: assert property (@(posedge clk) disable iff (rst)
    (smp_vld && !pend) |=> adm_bit == ($signed($past(smp_in)) >= $signed($past(estimate))));

  assert_clear_R2: assert property (@(posedge clk) disable iff (rst)
    (pend && adm_bit != $past(adm_bit)) |=> step_idx == '0);

  assert_run_R3: assert property (@(posedge clk) disable iff (rst)
    (pend && adm_bit == $past(adm_bit)) |=>
      (step_idx == $past(step_idx) + CNT_W'(1)) ||
      ($past(step_idx) == IDX_MAX && step_idx == IDX_MAX));

  assert_dir_R4: assert property (@(posedge clk) disable iff (rst)
    pend |=> ($past(adm_bit) ? $signed(estimate) >= $signed($past(estimate))
                             : $signed(estimate) <= $signed($past(estimate))));

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!smp_vld && !pend) |=> ($stable(adm_bit) && $stable(step_idx) && $stable(estimate)));

  assert_reset_R8: assert property (@(posedge clk)
    rst |=> (adm_bit == 1'b0 && step_idx == '0 && estimate == '0));
endmodule

bind adm_encoder adm_encoder_chk #(.IN_W(IN_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_in(smp_in),
  .adm_bit(adm_bit), .step_idx(step_idx), .estimate(estimate), .pend(pend_q)
);

// File: tb/test_adm_encoder.sv
`timescale 1ns/1ps
module test_adm_encoder;
  localparam int IN_W = 12;
  localparam int NV = 16;
  localparam int VIN [NV]  = '{100,100,100,100,100,  0,  0, 11, -5, -5, -5, -5, -5, -5, -5, -5};
  localparam int VBIT[NV]  = '{  1,  1,  1,  1,  1,  0,  0,  1,  0,  0,  0,  0,  0,  0,  1,  1};
  localparam int VIDX[NV]  = '{  0,  1,  2,  3,  3,  0,  1,  0,  0,  1,  2,  3,  3,  3,  0,  1};
  localparam int VEST[NV]  = '{  1,  3,  6, 10, 14, 13, 11, 12, 11,  9,  6,  2, -2, -6, -5, -3};

  logic clk = 0, rst = 1, smp_vld = 0;
  logic signed [IN_W-1:0] smp_in = '0;
  logic adm_bit;
  logic [1:0] step_idx;
  logic signed [IN_W-1:0] estimate;
  int n_chk = 0, n_bad = 0, cyc = 0;

  adm_encoder i_adm_encoder (.clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_in(smp_in),
    .adm_bit(adm_bit), .step_idx(step_idx), .estimate(estimate));

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; smp_vld = 0;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  task automatic strobe(input int v);
    @(negedge clk); smp_in = IN_W'(v); smp_vld = 1;
    @(negedge clk); smp_vld = 0;
    @(negedge clk);
  endtask

  initial begin
    int keep_bit, keep_idx, keep_est;
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R8 reset bit", adm_bit, 0);
    chk("R8 reset idx", step_idx, 0);
    chk("R8 reset est", estimate, 0);

    for (int i = 0; i < NV; i++) begin
      strobe(VIN[i]);
      chk($sformatf("R1 vec%0d bit", i), adm_bit, VBIT[i]);
      chk($sformatf("R2/R3 vec%0d idx", i), step_idx, VIDX[i]);
      chk($sformatf("R4 vec%0d est", i), estimate, VEST[i]);
    end

    keep_bit = adm_bit; keep_idx = step_idx; keep_est = estimate;
    smp_in = 12'sd1500;
    repeat (6) @(negedge clk);
    smp_in = -12'sd1500;
    repeat (3) @(negedge clk);
    chk("R7 hold bit", adm_bit, keep_bit);
    chk("R7 hold idx", step_idx, keep_idx);
    chk("R7 hold est", estimate, keep_est);

    do_reset();
    @(negedge clk); smp_in = 12'sd100; smp_vld = 1;
    @(negedge clk); smp_vld = 0;
    chk("R6 bit after one clock", adm_bit, 1);
    chk("R6 est not yet moved", estimate, 0);
    @(negedge clk);
    chk("R6 est after two clocks", estimate, 1);

    do_reset();
    @(negedge clk); smp_in = 12'sd100; smp_vld = 1;
    @(negedge clk); smp_in = 12'sd0;
    @(negedge clk); smp_vld = 0;
    chk("R9 bit vs updated estimate", adm_bit, 0);
    @(negedge clk);
    chk("R9 idx", step_idx, 0);
    chk("R9 est", estimate, 0);

    do_reset();
    for (int i = 0; i < 600; i++) strobe(2047);
    chk("R5 high clamp est", estimate, 2047);
    chk("R3 saturated idx", step_idx, 3);
    chk("R1 equal gives 1", adm_bit, 1);

    for (int i = 0; i < 1200; i++) strobe(-2048);
    chk("R5 low clamp est", (estimate == -12'sd2048 || estimate == -12'sd2047) ? 1 : 0, 1);
    chk("R2 toggling idx", step_idx, 0);

    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    chk("R8 mid-run reset est", estimate, 0);
    chk("R8 mid-run reset idx", step_idx, 0);
    chk("R8 mid-run reset bit", adm_bit, 0);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule